// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects up to 96 level-sensitive interrupt lines, organised in banks of 32. It drives a normal interrupt request and a fast interrupt request to a processor. Software reaches it through a simple 32-bit register bus with the APB access phases: a select cycle followed by an enable cycle. Each bank has three registers:

- a latched pending word, cleared by writing ones;
- an enable word;
- a mask word.

A vector register returns the number of the lowest active source, already multiplied by four, so that a handler can use it directly as a table offset. A read of zero tells the handler that nothing is left to service.

Source 0 is the external line. It never reaches the normal request or the vector. It feeds a trigger detector whose type is chosen by software, and that detector sets a fast-interrupt pending flag. A protection switch lets only privileged bus accesses change or observe the registers.

Top module: `ic_vec_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_o` and `fiq_o` are low, and the vector (offset 0x00) reads zero.
- R2: A high `src_i[n]` at a clock edge sets pending bit n%32 of bank n/32 at that edge. Bank k's pending word reads at offset 0x10+4k.
- R3: In a write to a pending word, each 1 clears that bit and each 0 leaves it unchanged. A source that is still high sets its bit again at the same edge, so the bit stays 1.
- R4: Enable words at 0x40+4k are written and read as whole 32-bit values. A set bit lets that source reach `irq_o` and the vector.
- R5: Mask words sit at 0x50+4k, and a set bit blocks its source. `irq_o` is the OR, over sources 1..95, of pending AND enable AND NOT mask. All-zero masks block nothing.
- R6: The vector at 0x00 reads (4 × n), where n is the lowest source number of 1 or more that is pending, enabled and unmasked. It reads 0 when there is no such source.
- R7: Bit 0 of offset 0x08 turns protection on. While it is on, a write with `priv_i`=0 is ignored and a read with `priv_i`=0 returns zero. Privileged accesses work as normal.
- R8: Bits [1:0] at offset 0x0C select the trigger type of source 0: 00 level high, 01 level low, 10 rising edge, 11 falling edge. A trigger sets the fast pending flag, which is bit 0 at 0x20 and is cleared by writing 1. A level trigger that is still active sets the flag again. `fiq_o` is the flag AND enable bit 0 AND NOT mask bit 0.
- R9: Fast pending words for banks other than 0 (0x20+4k, k>0), and bits 31:1 of bank 0's word, read zero.
- R10: Source 0 alone never raises `irq_o` and never appears in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 8 | Byte offset of the register |
| pwdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access is privileged |
| prdata_o | output | 32 | Read data, valid while selected |
| src_i | input | 96 | Interrupt source levels; bit 0 is the external line |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench places active sources on both sides of each bank boundary (31/32, 95) and pairs them with selective enables and masks. A priority encoder that is off by one, or that picks the highest source, then returns a wrong offset. A lone source 0 is used to catch a design that lets the external line into the normal request or the vector. Pending words are cleared while their source is still high, which exposes a clear that wins over the level. The external line is driven through all four trigger types, because an edge detector that behaves as a level, or an inverted polarity, leaves the fast flag in the wrong state after a clear. Unprivileged writes and reads under protection must leave the enables unchanged and read back zero.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PROT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FAST = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 8'h50;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  function automatic logic [ADDR_W-1:0] bank_ofs(input logic [ADDR_W-1:0] base, input int k);
    return base + ADDR_W'(4 * k);
  endfunction
endpackage

// File: rtl/ic_bank.sv
module ic_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic         ena_we_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] ena_o,
  output logic [W-1:0] msk_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] ena_q, ena_d;
  logic [W-1:0] msk_q, msk_d;
  logic [W-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_we_i ? wdata_i : '0;
    pend_d   = (pend_q & ~clr_bits) | src_i;
    ena_d    = ena_q;
    msk_d    = msk_q;
    if (ena_we_i) ena_d = wdata_i;
    if (msk_we_i) msk_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ena_q  <= '0;
      msk_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ena_q  <= ena_d;
      msk_q  <= msk_d;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
  assign msk_o  = msk_q;
endmodule

// File: rtl/ic_lowest_first.sv
module ic_lowest_first #(
  parameter int N  = 96,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ic_ext_trig.sv
module ic_ext_trig
  import ic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  line_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  flag_o
);
  logic line_q;
  logic flag_q, flag_d;
  logic hit;

  always_comb begin
    unique case (mode_i)
      TRIG_HIGH: hit = line_i;
      TRIG_LOW:  hit = !line_i;
      TRIG_RISE: hit = line_i && !line_q;
      default:   hit = !line_i && line_q;
    endcase
    flag_d = (flag_q && !clr_i) || hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      line_q <= line_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ic_vec_ctrl.sv
module ic_vec_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int BANK_W  = DATA_W,
  localparam int NUM_SRC = NUM_BANKS * BANK_W,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  input  logic               priv_i,
  output logic [DATA_W-1:0]  prdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic prot_q, prot_d;
  trig_e trig_q, trig_d;
  logic allow, wr_stb;

  assign allow  = !prot_q || priv_i;
  assign wr_stb = psel_i && penable_i && pwrite_i && allow;

  logic [NUM_BANKS-1:0] clr_we, ena_we, msk_we;
  logic [NUM_SRC-1:0]   pend_all, ena_all, msk_all, act;
  logic                 fast_flag, fast_clr;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign clr_we[k] = wr_stb && (paddr_i == bank_ofs(OFS_PEND, k));
    assign ena_we[k] = wr_stb && (paddr_i == bank_ofs(OFS_ENA, k));
    assign msk_we[k] = wr_stb && (paddr_i == bank_ofs(OFS_MSK, k));

    ic_bank #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_q),
      .src_i    (src_i[k*BANK_W +: BANK_W]),
      .clr_we_i (clr_we[k]),
      .ena_we_i (ena_we[k]),
      .msk_we_i (msk_we[k]),
      .wdata_i  (pwdata_i),
      .pend_o   (pend_all[k*BANK_W +: BANK_W]),
      .ena_o    (ena_all[k*BANK_W +: BANK_W]),
      .msk_o    (msk_all[k*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    prot_d = prot_q;
    trig_d = trig_q;
    if (wr_stb && paddr_i == OFS_PROT) prot_d = pwdata_i[0];
    if (wr_stb && paddr_i == OFS_TRIG) trig_d = trig_e'(pwdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      prot_q <= 1'b0;
      trig_q <= TRIG_HIGH;
    end else begin
      prot_q <= prot_d;
      trig_q <= trig_d;
    end
  end

  assign fast_clr = wr_stb && (paddr_i == OFS_FAST) && pwdata_i[0];

  ic_ext_trig u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .line_i (src_i[0]),
    .mode_i (trig_q),
    .clr_i  (fast_clr),
    .flag_o (fast_flag)
  );

  // Source 0 is reserved for the fast path and is dropped from the normal request.
  assign act = {pend_all[NUM_SRC-1:1] & ena_all[NUM_SRC-1:1] & ~msk_all[NUM_SRC-1:1], 1'b0};

  logic             vec_hit;
  logic [IDX_W-1:0] vec_idx;

  ic_lowest_first #(.N(NUM_SRC)) u_pick (
    .req_i (act),
    .hit_o (vec_hit),
    .idx_o (vec_idx)
  );

  assign irq_o = |act;
  assign fiq_o = fast_flag && ena_all[0] && !msk_all[0];

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (paddr_i == OFS_VEC && vec_hit) rd_word = DATA_W'({vec_idx, 2'b00});
    if (paddr_i == OFS_PROT)           rd_word = DATA_W'(prot_q);
    if (paddr_i == OFS_TRIG)           rd_word = DATA_W'(trig_q);
    if (paddr_i == OFS_FAST)           rd_word = DATA_W'(fast_flag);
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (paddr_i == bank_ofs(OFS_PEND, k)) rd_word = pend_all[k*BANK_W +: BANK_W];
      if (paddr_i == bank_ofs(OFS_ENA, k))  rd_word = ena_all[k*BANK_W +: BANK_W];
      if (paddr_i == bank_ofs(OFS_MSK, k))  rd_word = msk_all[k*BANK_W +: BANK_W];
    end
  end

  assign prdata_o = (psel_i && allow) ? rd_word : '0;
endmodule

// File: rtl/ic_vec_ctrl_chk.sv
module ic_vec_ctrl_chk #(
  parameter int NUM_SRC = 96,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_q,
  input logic               psel_i,
  input logic               penable_i,
  input logic               pwrite_i,
  input logic               priv_i,
  input logic               prot_q,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] pend_all,
  input logic [NUM_SRC-1:0] ena_all,
  input logic [NUM_SRC-1:0] msk_all,
  input logic [1:0]         trig_q,
  input logic               vec_hit,
  input logic [IDX_W-1:0]   vec_idx,
  input logic               irq_o,
  input logic               fiq_o
);
  // R2: a source seen high at an edge leaves its pending bit set
  a_r2_pend_follows_src: assert property (@(posedge clk_i) disable iff (!rst_q)
    $past(rst_q) |-> ((pend_all & $past(src_i)) == $past(src_i)));

  // R6: the encoder has a winner exactly when the request is up
  a_r6_vec_with_irq: assert property (@(posedge clk_i) disable iff (!rst_q)
    irq_o |-> vec_hit);
  a_r6_vec_quiet: assert property (@(posedge clk_i) disable iff (!rst_q)
    !irq_o |-> !vec_hit);

  // R6: the reported source is pending, enabled and unmasked
  a_r6_vec_is_active: assert property (@(posedge clk_i) disable iff (!rst_q)
    vec_hit |-> (pend_all[vec_idx] && ena_all[vec_idx] && !msk_all[vec_idx]));

  // R10: source 0 is never the vector
  a_r10_no_src0_vec: assert property (@(posedge clk_i) disable iff (!rst_q)
    vec_hit |-> (vec_idx != '0));

  // R7: unprivileged writes under protection change nothing
  a_r7_prot_blocks: assert property (@(posedge clk_i) disable iff (!rst_q)
    (prot_q && psel_i && penable_i && pwrite_i && !priv_i)
      |=> ($stable(ena_all) && $stable(msk_all) && $stable(trig_q) && prot_q));

  // R8: the fast request needs source 0 enabled and unmasked
  a_r8_fiq_gated: assert property (@(posedge clk_i) disable iff (!rst_q)
    fiq_o |-> (ena_all[0] && !msk_all[0]));
endmodule

bind ic_vec_ctrl ic_vec_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i     (clk_i),
  .rst_q     (rst_q),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .priv_i    (priv_i),
  .prot_q    (prot_q),
  .src_i     (src_i),
  .pend_all  (pend_all),
  .ena_all   (ena_all),
  .msk_all   (msk_all),
  .trig_q    (trig_q),
  .vec_hit   (vec_hit),
  .vec_idx   (vec_idx),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/ic_vec_ctrl_tb_top.sv
module ic_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, priv = 1'b1;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [95:0] src = '0;
  logic        irq, fiq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ic_vec_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .priv_i(priv),
    .prdata_o(prdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic [95:0] src;
    logic [95:0] ena;
    logic [95:0] msk;
    logic [31:0] vec;
    logic        irq;
  } row_t;

  localparam logic [95:0] ONE = 96'd1;
  localparam logic [95:0] ALL = '1;
  localparam row_t TBL [9] = '{
    '{ONE << 5,               ALL,       '0,         32'd20,  1'b1},
    '{(ONE << 40)|(ONE << 70), ALL,       '0,         32'd160, 1'b1},
    '{(ONE << 40)|(ONE << 70), ONE << 70, '0,         32'd280, 1'b1},
    '{(ONE << 40)|(ONE << 70), ALL,       ONE << 40,  32'd280, 1'b1},
    '{ONE,                    ALL,       '0,         32'd0,   1'b0},
    '{ONE << 95,              ALL,       '0,         32'd380, 1'b1},
    '{(ONE << 31)|(ONE << 32), ALL,       '0,         32'd124, 1'b1},
    '{'0,                     ALL,       '0,         32'd0,   1'b0},
    '{(ONE << 3)|(ONE << 64), ALL,       ALL,        32'd0,   1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_rd(8'h40, rd); check("R1 enable0", rd, 32'h0);
    bus_rd(8'h54, rd); check("R1 mask1", rd, 32'h0);
    bus_rd(8'h00, rd); check("R1 vector", rd, 32'h0);
    check("R1 irq_o", {31'b0, irq}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq}, 32'h0);

    // R5 R6 R10: table walk
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); src = TBL[i].src;
      for (int k = 0; k < 3; k++) begin
        bus_wr(8'h10 + 8'(4*k), 32'hFFFF_FFFF);
        bus_wr(8'h40 + 8'(4*k), TBL[i].ena[k*32 +: 32]);
        bus_wr(8'h50 + 8'(4*k), TBL[i].msk[k*32 +: 32]);
      end
      bus_rd(8'h00, rd); check($sformatf("R6 vector row %0d", i), rd, TBL[i].vec);
      check($sformatf("R5 R10 irq row %0d", i), {31'b0, irq}, {31'b0, TBL[i].irq});
    end

    // R2 R3: pending capture and write-one-to-clear
    @(negedge clk); src = ONE << 33;
    bus_wr(8'h10, 32'hFFFF_FFFF); bus_wr(8'h14, 32'hFFFF_FFFF); bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h14, rd); check("R2 bank1 bit1", rd, 32'h2);
    @(negedge clk); src = '0;
    bus_wr(8'h14, 32'h0); bus_rd(8'h14, rd); check("R3 zero write keeps", rd, 32'h2);
    bus_wr(8'h14, 32'h2); bus_rd(8'h14, rd); check("R3 one write clears", rd, 32'h0);
    @(negedge clk); src = ONE << 33;
    wait_edge();
    bus_wr(8'h14, 32'h2); bus_rd(8'h14, rd); check("R3 level re-sets", rd, 32'h2);
    @(negedge clk); src = '0;
    bus_wr(8'h14, 32'hFFFF_FFFF);

    // R4: whole-word enable access
    bus_wr(8'h44, 32'hA5A5_0003); bus_rd(8'h44, rd); check("R4 enable1 readback", rd, 32'hA5A5_0003);

    // R8 R9: external line trigger types
    bus_wr(8'h40, 32'h1); bus_wr(8'h50, 32'h0);
    bus_wr(8'h0C, 32'h2); bus_wr(8'h20, 32'h1);
    check("R8 fiq clear", {31'b0, fiq}, 32'h0);
    @(negedge clk); src[0] = 1'b1;
    wait_edge(); check("R8 rising sets", {31'b0, fiq}, 32'h1);
    bus_wr(8'h20, 32'h1); check("R8 rising clear holds", {31'b0, fiq}, 32'h0);
    bus_wr(8'h0C, 32'h0);
    wait_edge(); check("R8 high level sets", {31'b0, fiq}, 32'h1);
    bus_wr(8'h20, 32'h1); check("R8 high level re-sets", {31'b0, fiq}, 32'h1);
    bus_wr(8'h0C, 32'h1); bus_wr(8'h20, 32'h1);
    bus_rd(8'h20, rd); check("R8 low level idle", rd, 32'h0);
    @(negedge clk); src[0] = 1'b0;
    wait_edge(); check("R8 low level sets", {31'b0, fiq}, 32'h1);
    bus_wr(8'h0C, 32'h3); bus_wr(8'h20, 32'h1);
    check("R8 falling clear", {31'b0, fiq}, 32'h0);
    @(negedge clk); src[0] = 1'b1;
    wait_edge(); check("R8 no fall yet", {31'b0, fiq}, 32'h0);
    @(negedge clk); src[0] = 1'b0;
    wait_edge(); check("R8 falling sets", {31'b0, fiq}, 32'h1);
    bus_rd(8'h24, rd); check("R9 bank1 fast word", rd, 32'h0);
    bus_wr(8'h50, 32'h1); check("R8 mask blocks fiq", {31'b0, fiq}, 32'h0);

    // R7: protection
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h48, 32'h0000_00F0);
    priv = 1'b0;
    bus_wr(8'h48, 32'hFFFF_FFFF);
    bus_rd(8'h48, rd); check("R7 unpriv read zero", rd, 32'h0);
    priv = 1'b1;
    bus_rd(8'h48, rd); check("R7 unpriv write ignored", rd, 32'h0000_00F0);
    bus_wr(8'h48, 32'h0000_0F00);
    bus_rd(8'h48, rd); check("R7 priv write works", rd, 32'h0000_0F00);
    bus_wr(8'h08, 32'h0);
    priv = 1'b0;
    bus_rd(8'h48, rd); check("R7 off allows unpriv", rd, 32'h0000_0F00);
    priv = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule